// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates between a set of interrupt sources and hands the processor one interrupt at a time. Each source has its own control word, which holds a pending request bit, an enable bit and a four-bit priority level. A source request pulse sets the pending bit. Software reads and writes the control words through a simple register port. The block finds the enabled, pending source with the highest level. It offers that source to the CPU only when its level is strictly above the level now being serviced. The offer carries a trap number and the matching vector address.

When the CPU acknowledges an offer, the block saves the current service level on an internal stack and raises the current level to that of the accepted source. It also clears the source's pending bit. A return-from-interrupt strobe restores the saved level, so services nest cleanly. The CPU can also post a software trap with an explicit trap number. That trap is offered ahead of hardware requests and does not change the current level.

The controller is a three-state machine. `IDLE` means nothing is offered. `OFFER_HW` means a hardware source is offered. `OFFER_SW` means a software trap is offered. `IDLE` goes to `OFFER_SW` when a software trap is posted. Otherwise `IDLE` goes to `OFFER_HW` when a qualifying source exists. Both offer states return to `IDLE` on acknowledge. `OFFER_HW` also returns to `IDLE` on withdrawal, which happens when the offered source stops qualifying.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the current level is 0, and every control word reads as zero.
- R2: A control word is 6 bits. Bits [3:0] are the level, bit 4 is enable and bit 5 is the pending request. A write replaces the whole word, and the read port shows the word selected by the address combinationally.
- R3: Among pending, enabled sources with a nonzero level, the highest level wins. On a tie the lower source index wins.
- R4: The state goes from IDLE to OFFER_HW, and the interrupt output rises one clock later, only when the winner's level is strictly greater than the current level. An equal level is never offered.
- R5: A source whose level is 0 is never offered, even when it is pending and enabled.
- R6: For a hardware offer, the trap number is 10h plus the source index and the vector address is the trap number times four. For example, source 3 gives trap 13h and vector 4Ch.
- R7: An acknowledge during OFFER_HW does four things. It pushes the current level, makes the source's level current, clears that source's pending bit and returns the state to IDLE. The interrupt output is low on the next cycle.
- R8: A return strobe without acknowledge pops the saved level into the current level. With an empty stack, the current level becomes 0. The stack holds 16 levels.
- R9: A software trap pulse with a trap number goes to OFFER_SW ahead of any hardware source. The vector address is the number times four. An acknowledge pushes the current level and leaves it unchanged.
- R10: In OFFER_HW, if the offered source stops being pending, enabled and above the current level before acknowledge, the offer is withdrawn and the output drops.
- R11: A register write to a source in the same cycle as the acknowledge that would clear it takes precedence over the hardware clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 8 | Per-source request pulses; each sets that pending bit |
| reg_we_i | input | 1 | Control word write strobe |
| reg_addr_i | input | 3 | Source index for read and write |
| reg_wdata_i | input | 6 | Control word write data |
| reg_rdata_o | output | 6 | Control word of the addressed source |
| sw_trap_i | input | 1 | Software trap request pulse |
| sw_num_i | input | 8 | Trap number of the software trap |
| ack_i | input | 1 | CPU accepts the current offer |
| reti_i | input | 1 | CPU returns from a service |
| irq_o | output | 1 | Interrupt offered to the CPU |
| trap_o | output | 8 | Trap number of the offer |
| vec_o | output | 10 | Vector address of the offer |
| cur_lvl_o | output | 4 | Level now being serviced |

## Verification
The bench checks equal-level requests: a design that compares with greater-or-equal would nest a source under its own level. It sets up same-level ties raised in a single cycle, where a highest-index scan would pick the wrong vector. It covers returns on an empty stack, where a design could reload garbage instead of 0, and level-0 sources, which a naive arbiter might offer. It also covers a write colliding with acknowledge, a request cleared while offered (a design that does not withdraw would keep the output high), and a software trap posted alongside a hardware request, which must be offered first and must not raise the level.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_OFFER_HW = 2'd1,
        ST_OFFER_SW = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_SRC-1:0]                 set_i,
    input  logic                             we_i,
    input  logic [$clog2(N_SRC)-1:0]         waddr_i,
    input  logic [LVL_W+1:0]                 wdata_i,
    input  logic                             clr_i,
    input  logic [$clog2(N_SRC)-1:0]         clr_idx_i,
    output logic [N_SRC-1:0]                 req_o,
    output logic [N_SRC-1:0]                 en_o,
    output logic [N_SRC-1:0][LVL_W-1:0]      lvl_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = we_i && (waddr_i == g);
        assign hit_clr = clr_i && (clr_idx_i == g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_o[g] <= 1'b0;
                en_o[g]  <= 1'b0;
                lvl_o[g] <= '0;
            end else if (hit_wr) begin
                req_o[g] <= wdata_i[LVL_W+1];
                en_o[g]  <= wdata_i[LVL_W];
                lvl_o[g] <= wdata_i[LVL_W-1:0];
            end else begin
                req_o[g] <= set_i[g] | (req_o[g] & ~hit_clr);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 4
) (
    input  logic [N_SRC-1:0]             req_i,
    input  logic [N_SRC-1:0]             en_i,
    input  logic [N_SRC-1:0][LVL_W-1:0]  lvl_i,
    output logic                         valid_o,
    output logic [$clog2(N_SRC)-1:0]     idx_o,
    output logic [LVL_W-1:0]             lvl_o
);
    localparam int IDX_W = $clog2(N_SRC);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && en_i[i] && (lvl_i[i] != '0) && (lvl_i[i] > lvl_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LVL_W-1:0] din_i,
    output logic [LVL_W-1:0] top_o,
    output logic             empty_o
);
    localparam int SP_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]  sp;

    assign empty_o = (sp == '0);
    assign top_o   = empty_o ? '0 : mem[sp - SP_W'(1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push_i) begin
            if (sp != SP_W'(DEPTH)) sp <= sp + SP_W'(1);
        end else if (pop_i && !empty_o) begin
            sp <= sp - SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && (sp != SP_W'(DEPTH))) mem[sp[SP_W-1:0]] <= din_i;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int                N_SRC     = 8,
    parameter int                LVL_W     = 4,
    parameter int                STK_DEPTH = 16,
    parameter int                TRAP_W    = 8,
    parameter logic [TRAP_W-1:0] TRAP_BASE = 8'h10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              src_req_i,
    input  logic                          reg_we_i,
    input  logic [$clog2(N_SRC)-1:0]      reg_addr_i,
    input  logic [LVL_W+1:0]              reg_wdata_i,
    output logic [LVL_W+1:0]              reg_rdata_o,
    input  logic                          sw_trap_i,
    input  logic [TRAP_W-1:0]             sw_num_i,
    input  logic                          ack_i,
    input  logic                          reti_i,
    output logic                          irq_o,
    output logic [TRAP_W-1:0]             trap_o,
    output logic [TRAP_W+1:0]             vec_o,
    output logic [LVL_W-1:0]              cur_lvl_o
);
    import irq_ctrl_pkg::*;

    localparam int IDX_W = $clog2(N_SRC);

    ctl_state_t state, state_nx;
    logic [IDX_W-1:0]               sel, sel_nx;
    logic [N_SRC-1:0]               req, en;
    logic [N_SRC-1:0][LVL_W-1:0]    lvl;
    logic                           arb_valid;
    logic [IDX_W-1:0]               arb_idx;
    logic [LVL_W-1:0]               arb_lvl;
    logic [LVL_W-1:0]               cur_lvl, stk_top, sel_lvl;
    logic                           stk_empty, sw_pend, sel_ok;
    logic [TRAP_W-1:0]              sw_num;
    logic                           take_hw, take_sw, do_pop;
    logic                           st_idle, st_hw, st_sw;

    irq_src_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (src_req_i),
        .we_i      (reg_we_i),
        .waddr_i   (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .clr_i     (take_hw),
        .clr_idx_i (sel),
        .req_o     (req),
        .en_o      (en),
        .lvl_o     (lvl)
    );

    irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
        .req_i   (req),
        .en_i    (en),
        .lvl_i   (lvl),
        .valid_o (arb_valid),
        .idx_o   (arb_idx),
        .lvl_o   (arb_lvl)
    );

    irq_lvl_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (take_hw | take_sw),
        .pop_i   (do_pop),
        .din_i   (cur_lvl),
        .top_o   (stk_top),
        .empty_o (stk_empty)
    );

    assign st_idle = (state == ST_IDLE);
    assign st_hw   = (state == ST_OFFER_HW);
    assign st_sw   = (state == ST_OFFER_SW);
    assign take_hw = st_hw && ack_i;
    assign take_sw = st_sw && ack_i;
    assign do_pop  = reti_i && !ack_i;
    assign sel_lvl = lvl[sel];
    assign sel_ok  = req[sel] && en[sel] && (sel_lvl > cur_lvl);
    assign reg_rdata_o = {req[reg_addr_i], en[reg_addr_i], lvl[reg_addr_i]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            state <= state_nx;
            sel   <= sel_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        sel_nx   = sel;
        unique case (state)
            ST_IDLE: begin
                if (sw_pend) begin
                    state_nx = ST_OFFER_SW;
                end else if (arb_valid && (arb_lvl > cur_lvl)) begin
                    state_nx = ST_OFFER_HW;
                    sel_nx   = arb_idx;
                end
            end
            ST_OFFER_HW: begin
                if (ack_i || !sel_ok) state_nx = ST_IDLE;
            end
            ST_OFFER_SW: begin
                if (ack_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o  = 1'b0;
        trap_o = TRAP_BASE + TRAP_W'(sel);
        unique case (state)
            ST_IDLE:     irq_o = 1'b0;
            ST_OFFER_HW: irq_o = 1'b1;
            ST_OFFER_SW: begin
                irq_o  = 1'b1;
                trap_o = sw_num;
            end
            default:     irq_o = 1'b0;
        endcase
        vec_o = {trap_o, 2'b00};
    end

    // service level and software trap holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lvl <= '0;
            sw_pend <= 1'b0;
            sw_num  <= '0;
        end else begin
            if (take_hw)     cur_lvl <= sel_lvl;
            else if (do_pop) cur_lvl <= stk_top;
            if (sw_trap_i && !sw_pend) begin
                sw_pend <= 1'b1;
                sw_num  <= sw_num_i;
            end else if (take_sw) begin
                sw_pend <= 1'b0;
            end
        end
    end

    assign cur_lvl_o = cur_lvl;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int LVL_W  = 4,
    parameter int TRAP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [TRAP_W-1:0] trap_o,
    input logic [LVL_W-1:0]  cur_lvl_o,
    input logic              ack_i,
    input logic              reti_i,
    input logic              st_idle,
    input logic              st_hw,
    input logic              st_sw,
    input logic              sw_pend,
    input logic [TRAP_W-1:0] sw_num,
    input logic              arb_valid,
    input logic [LVL_W-1:0]  arb_lvl,
    input logic [LVL_W-1:0]  sel_lvl,
    input logic              stk_empty
);
    assert_lvl0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (arb_lvl != '0));

    assert_offer_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && !sw_pend && arb_valid && (arb_lvl > cur_lvl_o)) |=> irq_o);

    assert_no_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && !sw_pend && !(arb_valid && (arb_lvl > cur_lvl_o))) |=> !irq_o);

    assert_ack_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hw && ack_i) |=> (!irq_o && (cur_lvl_o == $past(sel_lvl))));

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && stk_empty) |=> (cur_lvl_o == '0));

    assert_sw_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && sw_pend) |=> (irq_o && (trap_o == $past(sw_num))));

    assert_sw_keeps_lvl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_sw && ack_i) |=> $stable(cur_lvl_o));

    assert_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_hw, st_sw}) && (st_idle != (st_hw || st_sw)));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.LVL_W(LVL_W), .TRAP_W(TRAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .trap_o    (trap_o),
    .cur_lvl_o (cur_lvl_o),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .st_idle   (st_idle),
    .st_hw     (st_hw),
    .st_sw     (st_sw),
    .sw_pend   (sw_pend),
    .sw_num    (sw_num),
    .arb_valid (arb_valid),
    .arb_lvl   (arb_lvl),
    .sel_lvl   (sel_lvl),
    .stk_empty (stk_empty)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_req = '0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       sw_trap = 1'b0;
    logic [7:0] sw_num = '0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq;
    logic [7:0] trap;
    logic [9:0] vec;
    logic [3:0] cur_lvl;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .sw_trap_i(sw_trap), .sw_num_i(sw_num),
        .ack_i(ack), .reti_i(reti), .irq_o(irq), .trap_o(trap),
        .vec_o(vec), .cur_lvl_o(cur_lvl)
    );

    // behavioural reference model
    int m_req[N], m_en[N], m_lvl[N];
    int m_off;   // 0 none, 1 hardware, 2 software
    int m_sel, m_cur, m_swp, m_swn;
    int m_stk[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_req[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
            m_off = 0; m_sel = 0; m_cur = 0; m_swp = 0; m_swn = 0;
            m_stk.delete();
        end else begin
            int best, n_off, n_sel, n_cur, sel_l;
            bit thw, tsw;
            thw = (m_off == 1) && ack;
            tsw = (m_off == 2) && ack;
            best = -1;
            for (int i = 0; i < N; i++)
                if (m_req[i] && m_en[i] && m_lvl[i] > 0 && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
            n_off = m_off; n_sel = m_sel; n_cur = m_cur;
            sel_l = m_lvl[m_sel];
            if (m_off == 0) begin
                if (m_swp) n_off = 2;
                else if (best >= 0 && m_lvl[best] > m_cur) begin n_off = 1; n_sel = best; end
            end else if (m_off == 2) begin
                if (ack) n_off = 0;
            end else begin
                if (ack || !(m_req[m_sel] && m_en[m_sel] && sel_l > m_cur)) n_off = 0;
            end
            if (thw || tsw) begin
                if (m_stk.size() < 16) m_stk.push_back(m_cur);
                if (thw) n_cur = sel_l;
            end else if (reti) begin
                n_cur = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
            end
            if (sw_trap && !m_swp) begin m_swp = 1; m_swn = sw_num; end
            else if (tsw) m_swp = 0;
            for (int i = 0; i < N; i++) begin
                if (reg_we && reg_addr == i) begin
                    m_lvl[i] = reg_wdata[3:0]; m_en[i] = reg_wdata[4]; m_req[i] = reg_wdata[5];
                end else begin
                    m_req[i] = (src_req[i] || (m_req[i] && !(thw && m_sel == i))) ? 1 : 0;
                end
            end
            m_off = n_off; m_sel = n_sel; m_cur = n_cur;
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", t, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            int mt, a;
            a = reg_addr;
            chk(tag, "irq", irq, (m_off != 0) ? 1 : 0);
            chk(tag, "cur_lvl", cur_lvl, m_cur);
            chk(tag, "rdata", reg_rdata, m_req[a] * 32 + m_en[a] * 16 + m_lvl[a]);
            if (m_off != 0) begin
                mt = (m_off == 2) ? m_swn : 'h10 + m_sel;
                chk(tag, "trap", trap, mt);
                chk(tag, "vec", vec, mt * 4);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int idx, input int lv, input int e, input int r);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(idx); reg_wdata = {1'(r), 1'(e), 4'(lv)};
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 20 && !irq; k++) @(negedge clk);
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    task automatic pulse_src(input logic [7:0] m);
        @(negedge clk); src_req = m; @(negedge clk); src_req = '0;
    endtask

    initial begin
        tag = "R1";
        idle(3);
        #1;
        chk("R1", "irq at reset", irq, 0);
        chk("R1", "cur_lvl at reset", cur_lvl, 0);
        chk("R1", "rdata at reset", reg_rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        tag = "R2";
        wr(3, 5, 1, 1);
        tag = "R6";
        wait_irq();
        chk("R6", "trap src3", trap, 'h13);
        chk("R6", "vec src3", vec, 'h4C);
        tag = "R7";
        @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
        #1;
        chk("R7", "irq after ack", irq, 0);
        chk("R7", "cur after ack", cur_lvl, 5);
        chk("R7", "req cleared src3", reg_rdata, 'h15);

        tag = "R4";
        wr(1, 5, 1, 1);
        idle(4); #1;
        chk("R4", "equal level not offered", irq, 0);
        wr(2, 7, 1, 0);
        pulse_src(8'h04);
        wait_irq();
        chk("R4", "nested trap", trap, 'h12);
        pulse_ack();
        idle(1);

        tag = "R8";
        pulse_reti(); #1;
        chk("R8", "pop to 5", cur_lvl, 5);
        pulse_reti();
        wait_irq();
        chk("R8", "src1 after return", trap, 'h11);
        pulse_ack();
        pulse_reti();
        pulse_reti(); #1;
        chk("R8", "empty stack gives 0", cur_lvl, 0);

        tag = "R3";
        wr(0, 9, 0, 1);
        wr(4, 9, 1, 0);
        wr(6, 9, 1, 0);
        pulse_src(8'h50);
        wait_irq();
        chk("R3", "tie lower index", trap, 'h14);
        pulse_ack();
        idle(3);
        pulse_reti();
        wait_irq();
        chk("R3", "second of tie", trap, 'h16);
        pulse_ack();
        pulse_reti();

        tag = "R5";
        wr(7, 0, 1, 1);
        idle(5); #1;
        chk("R5", "level 0 ignored", irq, 0);

        tag = "R9";
        wr(2, 3, 1, 0);
        @(negedge clk);
        sw_trap = 1'b1; sw_num = 8'h2A; src_req = 8'h04;
        @(negedge clk);
        sw_trap = 1'b0; src_req = '0;
        wait_irq();
        chk("R9", "sw trap first", trap, 'h2A);
        chk("R9", "sw vector", vec, 'hA8);
        pulse_ack(); #1;
        chk("R9", "sw keeps level", cur_lvl, 0);
        wait_irq();
        chk("R9", "hw after sw", trap, 'h12);
        pulse_ack();
        pulse_reti();
        pulse_reti();

        tag = "R10";
        wr(1, 4, 1, 1);
        wait_irq();
        wr(1, 4, 1, 0);
        idle(1); #1;
        chk("R10", "withdrawn", irq, 0);

        tag = "R11";
        wr(5, 6, 1, 1);
        wait_irq();
        @(negedge clk);
        ack = 1'b1; reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 6'h36;
        @(negedge clk);
        ack = 1'b0; reg_we = 1'b0;
        #1;
        chk("R11", "write beats clear", reg_rdata, 'h36);
        chk("R11", "cur after ack", cur_lvl, 6);
        pulse_reti();
        wait_irq();
        chk("R11", "reoffered", trap, 'h15);
        pulse_ack();
        pulse_reti();
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule